// File: doc/BRIEF.md
# Serial Symmetric x2 Interpolation Filter

This block doubles the sample rate of a mono stream of 18-bit signed audio samples. It does so with one pre-adder and one multiplier-accumulator, shared in time, instead of a parallel tapped delay line. Each accepted input sample is written into a 32-entry circular sample store. A sequencer then walks 7 symmetric sample pairs for each of two polyphase outputs. For each pair, the two samples are added into a 19-bit sum. The sum is multiplied by a 12-bit coefficient fetched from a 16-entry table that is fixed by a parameter. The 30-bit products are accumulated in a 34-bit register. Each finished sum is rounded, scaled down by 2^11 and clamped to 18 bits.

One input therefore costs 28 sample reads, 14 pre-additions and 14 multiply-accumulates, issued one per clock. The source feeding the block must space its strobes at least 16 clocks apart. A strobe that arrives while the engine is still working on the previous sample is refused and flagged.

Top module: `fir_interp_x2`

## Requirements
- R1: After reset, `busy`, `overrun` and `out_valid` are low, `out_phase` is 0, `out_data` is 0, and every sample in the store reads as zero.
- R2: An accepted sample becomes the newest entry. Offset k refers to the sample accepted k strobes earlier. The store holds 32 entries and wraps around, so a continuous run longer than 32 samples still sees the correct history for offsets 0 to 13.
- R3: An accepted sample yields two results, each marked by a one-cycle `out_valid` pulse. Phase 0 appears 8 rising edges after the accepting edge, and phase 1 appears 15 edges after it. `out_phase` is 0 for the first result and 1 for the second.
- R4: The phase p result is built from an accumulator that is cleared for each result. It equals the sum over j = 0..6 of C[7p+j]·(x[n−j] + x[n−13+j... see below]), where the second sample of pair j is x[n−(13−j)], C[i] is the table entry at index i (entry 0 in bits 11:0 of the table parameter), and entries 14 and 15 are never used.
- R5: Rounding adds 1024 to the sum and then shifts it arithmetically right by 11, so exact halves round toward positive infinity: 1024 gives 1, −1024 gives 0, and −1536 gives −1.
- R6: A rounded value above 131071 is output as 131071, and one below −131072 is output as −131072.
- R7: `busy` is high for the 15 cycles that follow an accepting edge. It falls on the same edge at which the phase 1 result appears.
- R8: When `in_valid` is high on an edge where `busy` is high, the sample is discarded: nothing is written and the pointer does not move. `overrun` pulses for one cycle after that edge, and the results still in progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 18 | Signed input sample |
| busy | output | 1 | Engine is computing results for the last accepted sample |
| overrun | output | 1 | One-cycle pulse: a strobe was refused |
| out_valid | output | 1 | One-cycle pulse: `out_data` holds a new result |
| out_phase | output | 1 | Polyphase index of the current result |
| out_data | output | 18 | Signed, rounded and saturated result |

## Verification
Two events can fall on the same clock edge: an incoming strobe, and the completion of a result or the release of `busy`. The bench places refused strobes on the edge that launches the first pair, on the edge at which the phase 0 result is registered, and on the edge at which the phase 1 result lands while `busy` is still high. On each of these edges it expects `overrun` to pulse and the result in flight to match the arithmetic model. It also expects later results to show that the refused sample never entered the history. The regular sweep then sends strobes at the minimum 16-cycle spacing, so a new sample is accepted on the edge right after `busy` drops.

// File: rtl/fir_pkg.sv
package fir_pkg;
    localparam int DATA_W_DEF = 18;
    localparam int COEF_W_DEF = 12;
    localparam int DEPTH_DEF  = 32;
    localparam int ROM_N_DEF  = 16;
    localparam int NPAIR_DEF  = 7;
    localparam int ACC_W_DEF  = 34;
    localparam int FRAC_DEF   = 11;

    // entry 0 in the low bits; entries 0..6 phase 0, 7..13 phase 1, 14..15 spare
    localparam logic [ROM_N_DEF*COEF_W_DEF-1:0] COEFS_DEF = {
        12'h000, 12'h000,
        12'h010, 12'hFE0, 12'h040, 12'hF80, 12'h100, 12'hE00, 12'h400,
        12'hFFB, 12'h014, 12'hFB5, 12'h12C, 12'h7FF, 12'h4AF, 12'hF42
    };
endpackage

// File: rtl/fir_sample_ram.sv
module fir_sample_ram #(
    parameter int DW    = 18,
    parameter int DEPTH = 32,
    parameter int OFF_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic signed [DW-1:0] wr_data,
    input  logic [OFF_W-1:0]     off_a,
    input  logic [OFF_W-1:0]     off_b,
    output logic signed [DW-1:0] rd_a,
    output logic signed [DW-1:0] rd_b
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
    } ram_t;

    ram_t st_d, st_q;
    logic [AW-1:0] addr_a, addr_b;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[st_q.wp] = wr_data;
            st_d.wp           = st_q.wp + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // newest sample sits one below the write pointer
    assign addr_a = st_q.wp - AW'(1) - AW'(off_a);
    assign addr_b = st_q.wp - AW'(1) - AW'(off_b);
    assign rd_a   = st_q.mem[addr_a];
    assign rd_b   = st_q.mem[addr_b];
endmodule

// File: rtl/fir_coef_rom.sv
module fir_coef_rom #(
    parameter int CW = 12,
    parameter int N  = 16,
    parameter int IW = 4,
    parameter logic [N*CW-1:0] COEFS = '0
) (
    input  logic [IW-1:0]        idx,
    output logic signed [CW-1:0] coef
);
    logic [CW-1:0] table_w [N];

    for (genvar i = 0; i < N; i++) begin : g_entry
        assign table_w[i] = COEFS[i*CW +: CW];
    end

    assign coef = table_w[idx];
endmodule

// File: rtl/fir_sequencer.sv
module fir_sequencer #(
    parameter int NPAIR  = 7,
    parameter int STEP_W = 3,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             issue,
    output logic             phase,
    output logic             first,
    output logic             last,
    output logic [OFF_W-1:0] off_a,
    output logic [OFF_W-1:0] off_b,
    output logic [IDX_W-1:0] coef_idx
);
    typedef struct packed {
        logic              active;
        logic              phase;
        logic [STEP_W-1:0] step;
    } seq_t;

    seq_t st_d, st_q;
    logic at_end;

    assign at_end = (st_q.step == STEP_W'(NPAIR - 1));

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.phase  = 1'b0;
            st_d.step   = '0;
        end else if (st_q.active) begin
            if (at_end) begin
                st_d.step = '0;
                if (st_q.phase) st_d.active = 1'b0;
                else            st_d.phase  = 1'b1;
            end else begin
                st_d.step = st_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign issue    = st_q.active;
    assign phase    = st_q.phase;
    assign first    = (st_q.step == '0);
    assign last     = at_end;
    assign off_a    = OFF_W'(st_q.step);
    assign off_b    = OFF_W'(2 * NPAIR - 1) - OFF_W'(st_q.step);
    assign coef_idx = st_q.phase ? IDX_W'(NPAIR) + IDX_W'(st_q.step) : IDX_W'(st_q.step);

    // R8
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !st_q.active);

    // R3
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && last && phase) |=> !issue);
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
    parameter int DW     = 18,
    parameter int CW     = 12,
    parameter int SUM_W  = 19,
    parameter int PROD_W = 30,
    parameter int ACC_W  = 34,
    parameter int FRAC   = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic                 first,
    input  logic                 last,
    input  logic                 phase,
    input  logic signed [DW-1:0] smp_a,
    input  logic signed [DW-1:0] smp_b,
    input  logic signed [CW-1:0] coef,
    output logic                 pend,
    output logic                 out_valid,
    output logic                 out_phase,
    output logic signed [DW-1:0] out_data
);
    localparam int FULL_W = SUM_W + CW;
    localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] SAT_HI = (ACC_W'(1) <<< (DW - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

    typedef struct packed {
        logic             s1v;
        logic             first;
        logic             last;
        logic             phase;
        logic [SUM_W-1:0] sum;
        logic [CW-1:0]    coef;
        logic [ACC_W-1:0] acc;
        logic             ov;
        logic             oph;
        logic [DW-1:0]    od;
    } mac_t;

    mac_t st_d, st_q;
    logic signed [FULL_W-1:0] prod_full;
    logic signed [ACC_W-1:0]  acc_nx, rnd, shifted;

    always_comb begin
        st_d      = st_q;
        prod_full = $signed(st_q.sum) * $signed(st_q.coef);
        acc_nx    = st_q.first ? ACC_W'(prod_full) : $signed(st_q.acc) + ACC_W'(prod_full);
        rnd       = acc_nx + HALF;
        shifted   = rnd >>> FRAC;

        // pre-add stage
        st_d.s1v = issue;
        if (issue) begin
            st_d.first = first;
            st_d.last  = last;
            st_d.phase = phase;
            st_d.sum   = SUM_W'(smp_a) + SUM_W'(smp_b);
            st_d.coef  = coef;
        end

        // multiply-accumulate stage
        st_d.ov = 1'b0;
        if (st_q.s1v) begin
            st_d.acc = acc_nx;
            if (st_q.last) begin
                st_d.ov  = 1'b1;
                st_d.oph = st_q.phase;
                if (shifted > SAT_HI)      st_d.od = SAT_HI[DW-1:0];
                else if (shifted < SAT_LO) st_d.od = SAT_LO[DW-1:0];
                else                       st_d.od = shifted[DW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend      = st_q.s1v;
    assign out_valid = st_q.ov;
    assign out_phase = st_q.oph;
    assign out_data  = st_q.od;

    // R4
    prod_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1v |-> (prod_full[FULL_W-1] == prod_full[PROD_W-1]));

    // R3
    out_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: rtl/fir_interp_x2.sv
module fir_interp_x2 #(
    parameter int DATA_W = fir_pkg::DATA_W_DEF,
    parameter int COEF_W = fir_pkg::COEF_W_DEF,
    parameter int DEPTH  = fir_pkg::DEPTH_DEF,
    parameter int ROM_N  = fir_pkg::ROM_N_DEF,
    parameter int NPAIR  = fir_pkg::NPAIR_DEF,
    parameter int ACC_W  = fir_pkg::ACC_W_DEF,
    parameter int FRAC   = fir_pkg::FRAC_DEF,
    parameter logic [ROM_N*COEF_W-1:0] COEFS = fir_pkg::COEFS_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     busy,
    output logic                     overrun,
    output logic                     out_valid,
    output logic                     out_phase,
    output logic signed [DATA_W-1:0] out_data
);
    localparam int SUM_W  = DATA_W + 1;
    localparam int PROD_W = SUM_W + COEF_W - 1;
    localparam int STEP_W = $clog2(NPAIR);
    localparam int IDX_W  = $clog2(ROM_N);
    localparam int OFF_W  = $clog2(DEPTH);

    if (2 * NPAIR > DEPTH || 2 * NPAIR > ROM_N) begin : g_bad_cfg
        $error("pair count does not fit sample store or coefficient table");
    end

    typedef struct packed {
        logic ovr;
    } top_t;

    top_t st_d, st_q;
    logic accept, issue, phase, first, last, pend;
    logic [OFF_W-1:0] off_a, off_b;
    logic [IDX_W-1:0] coef_idx;
    logic signed [DATA_W-1:0] smp_a, smp_b;
    logic signed [COEF_W-1:0] coef;

    assign busy   = issue | pend;
    assign accept = in_valid & ~busy;

    always_comb begin
        st_d     = st_q;
        st_d.ovr = in_valid & busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign overrun = st_q.ovr;

    fir_sample_ram #(.DW(DATA_W), .DEPTH(DEPTH), .OFF_W(OFF_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_data(in_data),
        .off_a(off_a), .off_b(off_b), .rd_a(smp_a), .rd_b(smp_b)
    );

    fir_coef_rom #(.CW(COEF_W), .N(ROM_N), .IW(IDX_W), .COEFS(COEFS)) u_rom (
        .idx(coef_idx), .coef(coef)
    );

    fir_sequencer #(.NPAIR(NPAIR), .STEP_W(STEP_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .issue(issue), .phase(phase),
        .first(first), .last(last), .off_a(off_a), .off_b(off_b), .coef_idx(coef_idx)
    );

    fir_mac #(.DW(DATA_W), .CW(COEF_W), .SUM_W(SUM_W), .PROD_W(PROD_W),
              .ACC_W(ACC_W), .FRAC(FRAC)) u_mac (
        .clk(clk), .rst_n(rst_n), .issue(issue), .first(first), .last(last),
        .phase(phase), .smp_a(smp_a), .smp_b(smp_b), .coef(coef), .pend(pend),
        .out_valid(out_valid), .out_phase(out_phase), .out_data(out_data)
    );

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid));

    // R3
    out_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(busy));
endmodule

// File: tb/fir_interp_x2_test.sv
`timescale 1ns/1ps
module fir_interp_x2_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [17:0] in_data = '0;
    logic busy, overrun, out_valid, out_phase;
    logic signed [17:0] out_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int hist[$];
    int got0, got1;
    int lcg = 12345;

    // phase 0 at indices 0..6, phase 1 at 7..13
    int cf[14] = '{-190, 1199, 2047, 300, -75, 20, -5,
                   1024, -512, 256, -128, 64, -32, 16};

    always #2 clk = ~clk;

    fir_interp_x2 uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .busy(busy), .overrun(overrun), .out_valid(out_valid),
        .out_phase(out_phase), .out_data(out_data)
    );

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint smp(int k);
        if (k < hist.size()) return hist[hist.size() - 1 - k];
        return 0;
    endfunction

    function automatic int model(int p);
        longint acc = 0;
        longint y;
        for (int j = 0; j < 7; j++)
            acc += cf[7*p + j] * (smp(j) + smp(13 - j));
        y = (acc + 1024) >>> 11;
        if (y > 131071) y = 131071;
        if (y < -131072) y = -131072;
        return int'(y);
    endfunction

    // called at a negedge; strobe is sampled at the next rising edge (E0)
    task automatic push(int x, int inj, string tag);
        int e0, e1, vtag0, vtag1;
        bit expv, expo;
        in_valid = 1'b1;
        in_data  = 18'(x);
        @(negedge clk);
        in_valid = 1'b0;
        hist.push_back(x);
        e0 = model(0);
        e1 = model(1);
        for (int t = 0; t < 16; t++) begin
            if (t > 0) @(negedge clk);
            // R7: busy for the 15 cycles after the accepting edge
            chk(busy == (t < 15), "R7", busy, t < 15);
            // R3: result pulses 8 and 15 edges after acceptance
            expv = (t == 8) || (t == 15);
            chk(out_valid == expv, "R3", out_valid, expv);
            if (t == 8) begin
                got0 = out_data;
                chk(out_phase == 1'b0, "R3", out_phase, 0);
                chk(out_data == e0, tag, out_data, e0);
            end
            if (t == 15) begin
                got1 = out_data;
                chk(out_phase == 1'b1, "R3", out_phase, 1);
                chk(out_data == e1, tag, out_data, e1);
            end
            // R8: overrun pulse after a refused strobe
            expo = (inj >= 0) && (t == inj + 1);
            chk(overrun == expo, "R8", overrun, expo);
            if (inj >= 0 && t == inj) begin
                in_valid = 1'b1;
                in_data  = 18'(x ^ 54321);
            end else if (inj >= 0 && t == inj + 1) begin
                in_valid = 1'b0;
            end
        end
        vtag0 = 0; vtag1 = 0;
    endtask

    function automatic int next_rand();
        lcg = lcg * 1103515245 + 12345;
        return (lcg >>> 8) % 131072 * (((lcg >>> 4) & 1) ? 1 : -1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: state during and after reset
        chk(busy == 0 && overrun == 0 && out_valid == 0, "R1", {busy, overrun, out_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0, "R1", busy, 0);
        chk(out_valid == 0 && out_phase == 0, "R1", {out_valid, out_phase}, 0);
        chk(out_data == 0, "R1", out_data, 0);
        chk(overrun == 0, "R1", overrun, 0);

        // R5: half-way roundings on a zero history
        push(1, -1, "R5");
        chk(got0 == 0, "R5", got0, 0);
        chk(got1 == 1, "R5", got1, 1);
        push(-1, -1, "R5");
        chk(got0 == 1, "R5", got0, 1);
        chk(got1 == -1, "R5", got1, -1);
        for (int i = 0; i < 14; i++) push(0, -1, "R4");

        // R4: impulses walk through every coefficient position
        foreach (cf[k]) begin
            push((k % 2) ? -3000 : 5000, -1, "R4");
            for (int i = 0; i < 14; i++) push(0, -1, "R4");
        end

        // R6: full-scale runs clamp the phase 0 result
        for (int i = 0; i < 14; i++) push(131071, -1, "R6");
        chk(got0 == 131071, "R6", got0, 131071);
        for (int i = 0; i < 14; i++) push(-131072, -1, "R6");
        chk(got0 == -131072, "R6", got0, -131072);
        for (int i = 0; i < 16; i++) push((i % 2) ? 131071 : -131072, -1, "R6");

        // R2: long run wraps the 32-entry store several times
        for (int i = 0; i < 100; i++) push(next_rand(), -1, "R2");

        // R8: refused strobes on the first-pair edge and both result edges
        push(70000, 0, "R8");
        push(-42000, 7, "R8");
        push(12345, 14, "R8");
        for (int i = 0; i < 14; i++) push(next_rand(), -1, "R8");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule